// File: doc/BRIEF.md
# Multi-Region Erase Sector Locator

This block turns a byte offset into a parallel flash array into the erase sector that holds it. The array can be split into as many as four erase regions. Each region has its own sector count and a sector length that is a power of two. Regions sit back to back, starting at offset zero. A command decoder sends an offset through a valid/ready request channel. One cycle later it gets back the sector length, the sector base address, the region index and an out-of-range flag. It uses these to size and align a sector erase.

The region configuration comes in two forms. One is a per-region set of count/length pairs. The other is a single uniform count/length pair, used when no per-region count is given. The configuration is captured only when `cfg_load` is pulsed. At that moment the block checks the layout rules, totals the chip length and counts the active regions. It also builds the four-byte query descriptors that describe each erase region to software. These results are registered and stay fixed until the next load.

Back-pressure follows the usual stream rules. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `resp_valid` is high and `resp_ready` is low, every response field stays frozen.

Top module: `sec_locator`

## Requirements
- R1: Region i spans count×length bytes, and regions follow one another from offset 0. `chip_len` is the sum of all active regions. A lookup returns the index and the sector length of the region that contains the offset.
- R2: The list of regions ends at the first region whose count is zero; that region and every later one are inactive. `region_count` reports how many regions are active.
- R3: The sector length of every active region must be a power of two, a multiple of 256 and below 2^24. Otherwise `cfg_err` is 1.
- R4: The start offset of every active region must be a multiple of that region's sector length. Otherwise `cfg_err` is 1.
- R5: `resp_base` is the offset after masking (see R6) with its low log2(sector length) bits cleared.
- R6: Before lookup, the offset is ANDed with `chip_len`−1, so offsets wrap across the chip size.
- R7: If per-region count 0 is zero, the uniform pair alone defines region 0. If both forms are given and the uniform size (count×length) is nonzero, it must equal the per-region total, otherwise `cfg_err` is 1. A configuration with no active region sets `cfg_err`.
- R8: `cfi_desc[32*i+:32]` describes region i in little-endian byte order. Bits 15:0 hold count−1 and bits 31:16 hold length/256. The descriptor of an inactive region is all zeros.
- R9: A response appears with `resp_valid` high in the cycle after acceptance. `req_ready` is low only while a response is held with `resp_ready` low, and during such a stall all response fields stay unchanged.
- R10: If the masked offset lies in no active region, the response has `resp_oor`=1, `resp_len`=0, `resp_base`=0 and `resp_region`=0.
- R11: `chip_len`, `cfg_err`, `region_count`, `cfi_desc` and the lookup map change only on a clock edge with `cfg_load` high. Changing the configuration inputs without a load has no effect.
- R12: After reset, `chip_len`=0, `cfg_err`=0, `region_count`=0, `resp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_count | input | NUM_REGIONS*CNT_W | Per-region sector counts, region i at bits [i*CNT_W +: CNT_W] |
| cfg_len | input | NUM_REGIONS*LEN_W | Per-region sector lengths in bytes, region i at bits [i*LEN_W +: LEN_W] |
| cfg_uni_count | input | CNT_W | Uniform sector count |
| cfg_uni_len | input | LEN_W | Uniform sector length in bytes |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_offset | input | OFS_W | Byte offset to locate |
| resp_valid | output | 1 | Lookup response valid |
| resp_ready | input | 1 | Consumer accepts the response |
| resp_len | output | LEN_W | Sector length, 0 when out of range |
| resp_base | output | OFS_W | Sector base address |
| resp_region | output | IDX_W | Index of the matching region |
| resp_oor | output | 1 | Offset is in no active region |
| chip_len | output | CHIP_W | Total length of the active regions |
| cfg_err | output | 1 | Captured configuration breaks a rule |
| region_count | output | NREG_W | Number of active regions |
| cfi_desc | output | NUM_REGIONS*32 | Per-region query descriptors |

## Verification
The bench uses a mixed layout with regions of different sizes and aims at the region edges. A comparator off by one there would report the wrong region or the wrong sector base just below or at a region start. It loads a zero count in the middle of the list with a nonzero count after it. A design that skips the zero instead of stopping would then report too many regions and a larger chip length. Length rules are tested one at a time (not a power of two, under 256, exactly 2^24), along with a region start that is not aligned, a uniform total that does not match the per-region total, and an empty map. Each case shows whether the error flag is raised where it should be and left clear for legal layouts. Offsets above the chip size check the wrap. A response stall with a new request waiting checks that a design which dropped or overwrote a held response, or took the new request early, would be caught.

// File: rtl/sec_loc_pkg.sv
package sec_loc_pkg;

  localparam int unsigned DESC_W          = 32;
  localparam int unsigned MIN_SECTOR_LOG2 = 8;
  localparam int unsigned MAX_SECTOR_LOG2 = 24;

  // Legal sector length: power of two, at least 256, below 2^24.
  function automatic logic sector_len_legal(input logic [63:0] len);
    logic pow2;
    logic low_clear;
    logic below_max;
    pow2      = (len != 64'd0) && ((len & (len - 64'd1)) == 64'd0);
    low_clear = (len & ((64'd1 << MIN_SECTOR_LOG2) - 64'd1)) == 64'd0;
    below_max = (len >> MAX_SECTOR_LOG2) == 64'd0;
    return pow2 && low_clear && below_max;
  endfunction

endpackage

// File: rtl/sec_loc_region_chk.sv
module sec_loc_region_chk #(
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned CHIP_W = 51
) (
  input  logic              active,
  input  logic [LEN_W-1:0]  sect_len,
  input  logic [CHIP_W-1:0] start,
  output logic              err
);
  import sec_loc_pkg::*;

  logic              legal;
  logic [CHIP_W-1:0] align_mask;
  logic              misaligned;

  assign legal      = sector_len_legal(64'(sect_len));
  assign align_mask = CHIP_W'(sect_len) - CHIP_W'(1);
  assign misaligned = (start & align_mask) != '0;
  assign err        = active && (!legal || misaligned);

endmodule

// File: rtl/sec_loc_cfg.sv
module sec_loc_cfg #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned CHIP_W      = 51,
  parameter int unsigned NREG_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cnt_in  [NUM_REGIONS],
  input  logic [LEN_W-1:0]  len_in  [NUM_REGIONS],
  input  logic [CNT_W-1:0]  uni_cnt,
  input  logic [LEN_W-1:0]  uni_len,
  output logic [CHIP_W-1:0] start_q [NUM_REGIONS],
  output logic [CHIP_W-1:0] end_q   [NUM_REGIONS],
  output logic [LEN_W-1:0]  len_q   [NUM_REGIONS],
  output logic [CHIP_W-1:0] chip_q,
  output logic              err_q,
  output logic [NREG_W-1:0] nreg_q,
  output logic [31:0]       desc_q  [NUM_REGIONS]
);
  import sec_loc_pkg::*;

  logic                   per_mode;
  logic [NUM_REGIONS-1:0] act;
  logic [NUM_REGIONS-1:0] reg_err;
  logic [CNT_W-1:0]       r_cnt   [NUM_REGIONS];
  logic [LEN_W-1:0]       r_len   [NUM_REGIONS];
  logic [CHIP_W-1:0]      r_size  [NUM_REGIONS];
  logic [CHIP_W-1:0]      r_start [NUM_REGIONS];
  logic [CHIP_W-1:0]      r_end   [NUM_REGIONS];
  logic [DESC_W-1:0]      desc_d  [NUM_REGIONS];
  logic [CHIP_W-1:0]      chip_d;
  logic [CHIP_W-1:0]      uni_size;
  logic                   mismatch;
  logic                   err_d;
  logic [NREG_W-1:0]      nreg_d;

  // The per-region form is in use when its first count is nonzero.
  assign per_mode = cnt_in[0] != '0;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    if (g == 0) begin : g_head
      assign r_cnt[g]   = per_mode ? cnt_in[g] : uni_cnt;
      assign r_len[g]   = per_mode ? len_in[g] : uni_len;
      assign act[g]     = r_cnt[g] != '0;
      assign r_start[g] = '0;
    end else begin : g_tail
      assign r_cnt[g]   = per_mode ? cnt_in[g] : '0;
      assign r_len[g]   = per_mode ? len_in[g] : '0;
      // A zero count ends the list: later regions stay inactive.
      assign act[g]     = act[g-1] && (r_cnt[g] != '0);
      assign r_start[g] = r_end[g-1];
    end

    assign r_size[g] = act[g] ? (CHIP_W'(r_cnt[g]) * CHIP_W'(r_len[g])) : '0;
    assign r_end[g]  = r_start[g] + r_size[g];

    sec_loc_region_chk #(
      .LEN_W (LEN_W),
      .CHIP_W(CHIP_W)
    ) chk_i (
      .active  (act[g]),
      .sect_len(r_len[g]),
      .start   (r_start[g]),
      .err     (reg_err[g])
    );

    // Query descriptor: count-1 in the low half, length/256 in the high half.
    assign desc_d[g] = act[g] ? {16'(r_len[g] >> MIN_SECTOR_LOG2),
                                 16'(r_cnt[g] - CNT_W'(1))}
                              : '0;
  end

  assign chip_d   = r_end[NUM_REGIONS-1];
  assign uni_size = CHIP_W'(uni_cnt) * CHIP_W'(uni_len);
  assign mismatch = per_mode && (uni_size != '0) && (uni_size != chip_d);
  assign err_d    = !act[0] || mismatch || (|reg_err);

  always_comb begin
    nreg_d = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      nreg_d = nreg_d + NREG_W'(act[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= '0;
      err_q  <= 1'b0;
      nreg_q <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
        len_q[i]   <= '0;
        desc_q[i]  <= '0;
      end
    end else if (cfg_load) begin
      chip_q <= chip_d;
      err_q  <= err_d;
      nreg_q <= nreg_d;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        start_q[i] <= r_start[i];
        end_q[i]   <= r_end[i];
        len_q[i]   <= act[i] ? r_len[i] : '0;
        desc_q[i]  <= desc_d[i];
      end
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(chip_q) && $stable(err_q) && $stable(nreg_q))); // R11

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_desc_chk
    AST_DESC_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_q[g] != '0) |-> (int'(nreg_q) > g)); // R8
  end

endmodule

// File: rtl/sec_loc_lookup.sv
module sec_loc_lookup #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned CHIP_W      = 51,
  parameter int unsigned OFS_W       = 32,
  parameter int unsigned IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFS_W-1:0]  req_offset,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [LEN_W-1:0]  resp_len,
  output logic [OFS_W-1:0]  resp_base,
  output logic [IDX_W-1:0]  resp_region,
  output logic              resp_oor,
  input  logic [CHIP_W-1:0] start_q [NUM_REGIONS],
  input  logic [CHIP_W-1:0] end_q   [NUM_REGIONS],
  input  logic [LEN_W-1:0]  len_q   [NUM_REGIONS],
  input  logic [CHIP_W-1:0] chip_q
);

  logic [CHIP_W-1:0]      wrap_mask;
  logic [CHIP_W-1:0]      off_ext;
  logic [OFS_W-1:0]       off_m;
  logic [NUM_REGIONS-1:0] hit;
  logic [IDX_W-1:0]       sel;
  logic                   found;
  logic [LEN_W-1:0]       sel_len;
  logic [OFS_W-1:0]       sel_base;
  logic                   accept;

  // Wrap the offset across the chip size.
  assign wrap_mask = chip_q - CHIP_W'(1);
  assign off_ext   = CHIP_W'(req_offset) & wrap_mask;
  assign off_m     = OFS_W'(off_ext);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
    assign hit[g] = (len_q[g] != '0) && (off_ext >= start_q[g]) && (off_ext < end_q[g]);
  end

  // Lowest-numbered matching region wins.
  always_comb begin
    sel = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) sel = IDX_W'(i);
    end
  end

  assign found    = |hit;
  assign sel_len  = found ? len_q[sel] : '0;
  assign sel_base = found ? (off_m & ~(OFS_W'(sel_len) - OFS_W'(1))) : '0;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_len    <= '0;
      resp_base   <= '0;
      resp_region <= '0;
      resp_oor    <= 1'b0;
    end else if (accept) begin
      resp_valid  <= 1'b1;
      resp_len    <= sel_len;
      resp_base   <= sel_base;
      resp_region <= found ? sel : '0;
      resp_oor    <= !found;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid); // R9

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_len) && $stable(resp_base)
                                     && $stable(resp_region) && $stable(resp_oor))); // R9

  AST_OOR_NO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_oor) |-> ((resp_len == '0) && (resp_base == '0))); // R10

endmodule

// File: rtl/sec_locator.sv
module sec_locator #(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned OFS_W       = 32,
  localparam int unsigned CHIP_W     = CNT_W + LEN_W + $clog2(NUM_REGIONS) + 1,
  localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned NREG_W     = $clog2(NUM_REGIONS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_load,
  input  logic [NUM_REGIONS*CNT_W-1:0] cfg_count,
  input  logic [NUM_REGIONS*LEN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0]             cfg_uni_count,
  input  logic [LEN_W-1:0]             cfg_uni_len,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [OFS_W-1:0]             req_offset,
  output logic                         resp_valid,
  input  logic                         resp_ready,
  output logic [LEN_W-1:0]             resp_len,
  output logic [OFS_W-1:0]             resp_base,
  output logic [IDX_W-1:0]             resp_region,
  output logic                         resp_oor,
  output logic [CHIP_W-1:0]            chip_len,
  output logic                         cfg_err,
  output logic [NREG_W-1:0]            region_count,
  output logic [NUM_REGIONS*32-1:0]    cfi_desc
);

  logic [CNT_W-1:0]  cnt_arr  [NUM_REGIONS];
  logic [LEN_W-1:0]  len_arr  [NUM_REGIONS];
  logic [CHIP_W-1:0] start_q  [NUM_REGIONS];
  logic [CHIP_W-1:0] end_q    [NUM_REGIONS];
  logic [LEN_W-1:0]  len_q    [NUM_REGIONS];
  logic [31:0]       desc_arr [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_flat
    assign cnt_arr[g]           = cfg_count[g*CNT_W +: CNT_W];
    assign len_arr[g]           = cfg_len[g*LEN_W +: LEN_W];
    assign cfi_desc[g*32 +: 32] = desc_arr[g];
  end

  sec_loc_cfg #(
    .NUM_REGIONS(NUM_REGIONS),
    .CNT_W      (CNT_W),
    .LEN_W      (LEN_W),
    .CHIP_W     (CHIP_W),
    .NREG_W     (NREG_W)
  ) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_load(cfg_load),
    .cnt_in  (cnt_arr),
    .len_in  (len_arr),
    .uni_cnt (cfg_uni_count),
    .uni_len (cfg_uni_len),
    .start_q (start_q),
    .end_q   (end_q),
    .len_q   (len_q),
    .chip_q  (chip_len),
    .err_q   (cfg_err),
    .nreg_q  (region_count),
    .desc_q  (desc_arr)
  );

  sec_loc_lookup #(
    .NUM_REGIONS(NUM_REGIONS),
    .LEN_W      (LEN_W),
    .CHIP_W     (CHIP_W),
    .OFS_W      (OFS_W),
    .IDX_W      (IDX_W)
  ) lookup_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_offset (req_offset),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_len   (resp_len),
    .resp_base  (resp_base),
    .resp_region(resp_region),
    .resp_oor   (resp_oor),
    .start_q    (start_q),
    .end_q      (end_q),
    .len_q      (len_q),
    .chip_q     (chip_len)
  );

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (cfg_count[CNT_W-1:0] == '0) && (cfg_uni_count == '0))
      |=> (region_count == '0 && cfg_err)); // R7

endmodule

// File: tb/sec_locator_tb_top.sv
module sec_locator_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [63:0]  cfg_count = '0;
  logic [127:0] cfg_len = '0;
  logic [15:0]  cfg_uni_count = '0;
  logic [31:0]  cfg_uni_len = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_offset = '0;
  logic         resp_valid;
  logic         resp_ready = 1'b1;
  logic [31:0]  resp_len;
  logic [31:0]  resp_base;
  logic [1:0]   resp_region;
  logic         resp_oor;
  logic [50:0]  chip_len;
  logic         cfg_err;
  logic [2:0]   region_count;
  logic [127:0] cfi_desc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_locator dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .cfg_len(cfg_len), .cfg_uni_count(cfg_uni_count), .cfg_uni_len(cfg_uni_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_offset(req_offset),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_len(resp_len),
    .resp_base(resp_base), .resp_region(resp_region), .resp_oor(resp_oor),
    .chip_len(chip_len), .cfg_err(cfg_err), .region_count(region_count),
    .cfi_desc(cfi_desc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] c0, input logic [31:0] l0,
                         input logic [15:0] c1, input logic [31:0] l1,
                         input logic [15:0] c2, input logic [31:0] l2,
                         input logic [15:0] c3, input logic [31:0] l3,
                         input logic [15:0] uc, input logic [31:0] ul);
    @(negedge clk);
    cfg_count     = {c3, c2, c1, c0};
    cfg_len       = {l3, l2, l1, l0};
    cfg_uni_count = uc;
    cfg_uni_len   = ul;
  endtask

  task automatic load_cfg();
    @(negedge clk) cfg_load = 1'b1;
    @(negedge clk) cfg_load = 1'b0;
  endtask

  task automatic look(input logic [31:0] off);
    @(negedge clk);
    req_valid  = 1'b1;
    req_offset = off;
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] off, input logic [1:0] region,
                            input logic [31:0] len, input logic [31:0] base);
    look(off);
    check({tag, " valid"}, 64'(resp_valid), 64'd1);
    check({tag, " region"}, 64'(resp_region), 64'(region));
    check({tag, " len"}, 64'(resp_len), 64'(len));
    check({tag, " base"}, 64'(resp_base), 64'(base));
    check({tag, " oor"}, 64'(resp_oor), 64'd0);
  endtask

  task automatic cfg_mixed();
    set_cfg(16'd4, 32'h1000, 16'd2, 32'h4000, 16'd1, 32'h4000, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
  endtask

  task automatic t_reset();
    check("R12 chip_len", 64'(chip_len), 64'd0);
    check("R12 cfg_err", 64'(cfg_err), 64'd0);
    check("R12 region_count", 64'(region_count), 64'd0);
    check("R12 resp_valid", 64'(resp_valid), 64'd0);
    check("R12 req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_mixed();
    cfg_mixed();
    check("R1 chip_len", 64'(chip_len), 64'h10000);
    check("R1 cfg_err", 64'(cfg_err), 64'd0);
    check("R2 region_count", 64'(region_count), 64'd3);
    expect_hit("R1 r0", 32'h1234, 2'd0, 32'h1000, 32'h1000);
    expect_hit("R5 r0 top", 32'h3FFF, 2'd0, 32'h1000, 32'h3000);
    expect_hit("R1 r1 start", 32'h4000, 2'd1, 32'h4000, 32'h4000);
    expect_hit("R5 r1", 32'h5678, 2'd1, 32'h4000, 32'h4000);
    expect_hit("R1 r2", 32'hC010, 2'd2, 32'h4000, 32'hC000);
    check("R8 desc0", 64'(cfi_desc[31:0]), 64'h0010_0003);
    check("R8 desc1", 64'(cfi_desc[63:32]), 64'h0040_0001);
    check("R8 desc2", 64'(cfi_desc[95:64]), 64'h0040_0000);
    check("R8 desc3", 64'(cfi_desc[127:96]), 64'h0);
  endtask

  task automatic t_wrap();
    expect_hit("R6 wrap low", 32'h0001_2345, 2'd0, 32'h1000, 32'h2000);
    expect_hit("R6 wrap high", 32'hFFFF_BFFF, 2'd1, 32'h4000, 32'h8000);
  endtask

  task automatic t_terminate();
    set_cfg(16'd4, 32'h1000, 16'd2, 32'h4000, 16'd0, 32'h4000, 16'd5, 32'h100, 16'd0, 32'h0);
    load_cfg();
    check("R2 count after gap", 64'(region_count), 64'd2);
    check("R2 chip_len", 64'(chip_len), 64'hC000);
    check("R2 cfg_err", 64'(cfg_err), 64'd0);
    check("R2 desc2 zero", 64'(cfi_desc[95:64]), 64'h0);
    check("R2 desc3 zero", 64'(cfi_desc[127:96]), 64'h0);
  endtask

  task automatic t_len_rules();
    set_cfg(16'd1, 32'h1800, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R3 non power of two", 64'(cfg_err), 64'd1);
    set_cfg(16'd1, 32'h80, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R3 below 256", 64'(cfg_err), 64'd1);
    set_cfg(16'd1, 32'h0100_0000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R3 at 2^24", 64'(cfg_err), 64'd1);
    set_cfg(16'd1, 32'h0080_0000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R3 2^23 legal", 64'(cfg_err), 64'd0);
    check("R3 2^23 chip", 64'(chip_len), 64'h80_0000);
  endtask

  task automatic t_align();
    set_cfg(16'd1, 32'h1000, 16'd1, 32'h2000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R4 misaligned start", 64'(cfg_err), 64'd1);
    set_cfg(16'd2, 32'h1000, 16'd1, 32'h2000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R4 aligned start", 64'(cfg_err), 64'd0);
    check("R4 chip_len", 64'(chip_len), 64'h4000);
    expect_hit("R4 r1", 32'h2800, 2'd1, 32'h2000, 32'h2000);
  endtask

  task automatic t_uniform();
    set_cfg(16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd8, 32'h1000);
    load_cfg();
    check("R7 uniform err", 64'(cfg_err), 64'd0);
    check("R7 uniform count", 64'(region_count), 64'd1);
    check("R7 uniform chip", 64'(chip_len), 64'h8000);
    check("R8 uniform desc0", 64'(cfi_desc[31:0]), 64'h0010_0007);
    expect_hit("R7 uniform", 32'h7FFF, 2'd0, 32'h1000, 32'h7000);
    set_cfg(16'd4, 32'h1000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd2, 32'h1000);
    load_cfg();
    check("R7 size mismatch", 64'(cfg_err), 64'd1);
    set_cfg(16'd4, 32'h1000, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd4, 32'h1000);
    load_cfg();
    check("R7 size match", 64'(cfg_err), 64'd0);
  endtask

  task automatic t_empty();
    set_cfg(16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0);
    load_cfg();
    check("R7 empty err", 64'(cfg_err), 64'd1);
    check("R7 empty chip", 64'(chip_len), 64'd0);
    look(32'h40);
    check("R10 oor flag", 64'(resp_oor), 64'd1);
    check("R10 oor len", 64'(resp_len), 64'd0);
    check("R10 oor base", 64'(resp_base), 64'd0);
    check("R10 oor region", 64'(resp_region), 64'd0);
  endtask

  task automatic t_hold();
    cfg_mixed();
    set_cfg(16'd8, 32'h100, 16'd0, 32'h0, 16'd0, 32'h0, 16'd0, 32'h0, 16'd3, 32'h1800);
    repeat (3) @(negedge clk);
    check("R11 chip held", 64'(chip_len), 64'h10000);
    check("R11 err held", 64'(cfg_err), 64'd0);
    check("R11 count held", 64'(region_count), 64'd3);
    expect_hit("R11 map held", 32'h5678, 2'd1, 32'h4000, 32'h4000);
  endtask

  task automatic t_stream();
    cfg_mixed();
    @(negedge clk);
    req_valid  = 1'b1;
    req_offset = 32'h1234;
    resp_ready = 1'b0;
    @(negedge clk);
    check("R9 valid after accept", 64'(resp_valid), 64'd1);
    check("R9 ready low in stall", 64'(req_ready), 64'd0);
    req_offset = 32'hC010;
    @(negedge clk);
    check("R9 held valid", 64'(resp_valid), 64'd1);
    check("R9 held base", 64'(resp_base), 64'h1000);
    check("R9 held region", 64'(resp_region), 64'd0);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next valid", 64'(resp_valid), 64'd1);
    check("R9 next base", 64'(resp_base), 64'hC000);
    check("R9 next region", 64'(resp_region), 64'd2);
    @(negedge clk);
    check("R9 drained", 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_wrap();
    t_terminate();
    t_len_rules();
    t_align();
    t_uniform();
    t_empty();
    t_hold();
    t_stream();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule